// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable slave that answers a master exactly as a 128-byte, byte-wide, three-wire serial EEPROM would. A controller under test drives chip select, a serial clock and a serial data line. The model decodes each instruction, shifts read data back on its data-out line, and changes its register-held array when a programming instruction arrives. It also keeps a write-enable latch, so that a controller which forgets to unlock the part sees its programming instructions have no effect.

The three slave inputs are asynchronous to the system clock. They pass through a short synchronizer, and serial clock rising edges are detected in the system clock domain. Each programming instruction starts an internal write period whose length is a parameter counted in system clocks. While chip select is high during that period, data out is held low. Once the period ends, data out returns high, which is how a master polls for completion.

Top module: `seeprom_model`

## Requirements
- R1: After reset every array byte reads 0xFF, the write-enable latch is clear, and data out is high whenever chip select is low.
- R2: After chip select rises, zeros on data in are skipped. The first 1 sampled on a serial clock rising edge is the start bit. It is followed by a 2-bit opcode and then a 7-bit address, each most significant bit first.
- R3: Opcode 2'b10 reads. The addressed byte appears on data out most significant bit first. Bit 7 is present after the last address edge, and each further serial clock rising edge advances by one bit.
- R4: Opcode 2'b01 takes 8 data bits, most significant bit first, and programs them into the addressed byte.
- R5: Opcode 2'b11 sets the addressed byte to 0xFF.
- R6: Opcode 2'b00 with address bits [6:5] = 2'b11 sets the write-enable latch, and with 2'b00 clears it.
- R7: Opcode 2'b00 with address bits [6:5] = 2'b10 sets every byte to 0xFF. With 2'b01 it takes 8 data bits and writes that byte to every location.
- R8: While the write-enable latch is clear, write, erase, erase-all and write-all change no byte and start no write period.
- R9: A programming instruction commits on its final bit. For WRITE_CYCLES system clocks after that, data out is low while chip select is high; afterwards it is high.
- R10: During the write period, start bits are ignored, so an instruction sent then has no effect.
- R11: If chip select falls before an instruction is complete, the instruction is abandoned, no byte changes and no write period starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSel | input | 1 | Chip select from the master, active high |
| serClk | input | 1 | Serial clock from the master |
| dataIn | input | 1 | Serial data from the master |
| dataOut | output | 1 | Serial data to the master; low means busy during a write period |

## Verification
Every input passes two synchronizer flops and an edge-detect flop, so an action tied to a serial clock edge takes effect about three system clocks after the edge. The bench therefore holds each serial level for 8 clocks and samples data out at least 4 clocks after the change that moves it, always on the falling system clock edge. The busy level is sampled 6 clocks after chip select is reasserted, roughly 20 clocks after the commit. The released level is sampled more than WRITE_CYCLES + 40 clocks after the commit, so neither sample falls near a transition.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int OP_W     = 2;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int HDR_BITS = OP_W + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);

  localparam logic [DATA_W-1:0] ERASED = '1;

  localparam logic [OP_W-1:0] OP_SPECIAL = 2'b00;
  localparam logic [OP_W-1:0] OP_WRITE   = 2'b01;
  localparam logic [OP_W-1:0] OP_READ    = 2'b10;
  localparam logic [OP_W-1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_HDR, ST_DATA, ST_READ, ST_DONE
  } state_e;

  typedef struct packed {
    logic              loadRead;
    logic              shiftRead;
    logic              progOne;
    logic              progAll;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] value;
  } strobe_t;
endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csActive,
  input  logic    sckLevel,
  input  logic    dataBit,
  input  logic    busy,
  output strobe_t strb,
  output logic    readMode
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  state_e              state, stateNext;
  logic                sckPrev, sckRise;
  logic [HDR_BITS-1:0] hdrQ, hdrNext, hdrFull;
  logic [DATA_W-1:0]   datQ, datNext, datFull;
  logic [CNT_W-1:0]    cntQ, cntNext;
  logic                wenQ, wenNext;
  logic [OP_W-1:0]     newOp, heldOp;
  logic [ADDR_W-1:0]   newAddr;
  logic [1:0]          newSub;

  assign sckRise = sckLevel & ~sckPrev;
  assign hdrFull = {hdrQ[HDR_BITS-2:0], dataBit};
  assign datFull = {datQ[DATA_W-2:0], dataBit};
  assign newOp   = hdrFull[HDR_BITS-1 -: OP_W];
  assign newAddr = hdrFull[ADDR_W-1:0];
  assign newSub  = newAddr[ADDR_W-1 -: 2];
  assign heldOp  = hdrQ[HDR_BITS-1 -: OP_W];

  always_comb begin
    stateNext      = state;
    hdrNext        = hdrQ;
    datNext        = datQ;
    cntNext        = cntQ;
    wenNext        = wenQ;
    strb           = '0;
    strb.addr      = hdrQ[ADDR_W-1:0];
    strb.value     = ERASED;
    if (!csActive) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_HUNT;
        ST_HUNT: begin
          if (sckRise && dataBit && !busy) begin
            stateNext = ST_HDR;
            cntNext   = '0;
          end
        end
        ST_HDR: begin
          if (sckRise) begin
            hdrNext = hdrFull;
            cntNext = cntQ + 1'b1;
            if (cntQ == HDR_LAST) begin
              cntNext   = '0;
              stateNext = ST_DONE;
              strb.addr = newAddr;
              unique case (newOp)
                OP_READ: begin
                  strb.loadRead = 1'b1;
                  stateNext     = ST_READ;
                end
                OP_WRITE: stateNext = ST_DATA;
                OP_ERASE: strb.progOne = wenQ;
                default: begin
                  unique case (newSub)
                    SUB_UNLOCK: wenNext = 1'b1;
                    SUB_LOCK:   wenNext = 1'b0;
                    SUB_WIPE:   strb.progAll = wenQ;
                    default:    stateNext = ST_DATA;
                  endcase
                end
              endcase
            end
          end
        end
        ST_DATA: begin
          if (sckRise) begin
            datNext = datFull;
            cntNext = cntQ + 1'b1;
            if (cntQ == DAT_LAST) begin
              stateNext  = ST_DONE;
              strb.value = datFull;
              if (heldOp == OP_WRITE) strb.progOne = wenQ;
              else                    strb.progAll = wenQ;
            end
          end
        end
        ST_READ: strb.shiftRead = sckRise;
        default: stateNext = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sckPrev <= 1'b0;
      hdrQ    <= '0;
      datQ    <= '0;
      cntQ    <= '0;
      wenQ    <= 1'b0;
    end else begin
      state   <= stateNext;
      sckPrev <= sckLevel;
      hdrQ    <= hdrNext;
      datQ    <= datNext;
      cntQ    <= cntNext;
      wenQ    <= wenNext;
    end
  end

  assign readMode = (state == ST_READ);

  a_r11_deselect_idles: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> state == ST_IDLE);
  a_r8_locked_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progOne || strb.progAll) |-> wenQ);
  a_r10_busy_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && busy) |=> state != ST_HDR);
  a_r3_shift_only_reading: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftRead |-> readMode);
endmodule

// File: rtl/seeprom_datapath.sv
module seeprom_datapath
  import seeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csActive,
  input  logic    readMode,
  input  strobe_t strb,
  output logic    busy,
  output logic    dataOut
);
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WRITE_CYCLES);

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [DATA_W-1:0] readShift;
  logic [BUSY_W-1:0] busyCnt;
  logic              progAny;

  assign progAny = strb.progOne | strb.progAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= ERASED;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.progAll || (strb.progOne && strb.addr == ADDR_W'(i)))
          memQ[i] <= strb.value;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readShift <= ERASED;
    end else if (strb.loadRead) begin
      readShift <= memQ[strb.addr];
    end else if (strb.shiftRead) begin
      readShift <= {readShift[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busyCnt <= '0;
    else if (progAny)        busyCnt <= BUSY_LOAD;
    else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);

  always_comb begin
    if (!csActive)     dataOut = 1'b1;
    else if (busy)     dataOut = 1'b0;
    else if (readMode) dataOut = readShift[DATA_W-1];
    else               dataOut = 1'b1;
  end

  a_r4_word_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.progOne |=> memQ[$past(strb.addr)] == $past(strb.value));
  a_r10_no_prog_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    progAny |-> !busy);
  a_r9_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progAny));
  a_r3_load_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |-> csActive);
endmodule

// File: rtl/seeprom_model.sv
module seeprom_model
  import seeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic dataIn,
  output logic dataOut
);
  logic    csActive, sckLevel, dataBit, busy, readMode;
  strobe_t strb;

  seeprom_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({chipSel, serClk, dataIn}),
    .dout ({csActive, sckLevel, dataBit})
  );

  seeprom_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csActive (csActive),
    .sckLevel (sckLevel),
    .dataBit  (dataBit),
    .busy     (busy),
    .strb     (strb),
    .readMode (readMode)
  );

  seeprom_datapath #(.WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .csActive (csActive),
    .readMode (readMode),
    .strb     (strb),
    .busy     (busy),
    .dataOut  (dataOut)
  );
endmodule

// File: tb/tb_seeprom_model.sv
`timescale 1ns/1ps
module tb_seeprom_model;
  localparam int WR = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, dataIn = 1'b0;
  logic dataOut;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seeprom_model #(.WRITE_CYCLES(WR)) dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic selectChip();
    chipSel = 1'b1; waitClk(8);
  endtask

  task automatic deselectChip();
    chipSel = 1'b0; dataIn = 1'b0; waitClk(8);
  endtask

  task automatic sendBit(input logic b);
    dataIn = b; waitClk(8);
    serClk = 1'b1; waitClk(8);
    serClk = 1'b0;
  endtask

  task automatic sendHeader(input logic [1:0] op, input logic [6:0] a);
    sendBit(1'b1);
    for (int i = 1; i >= 0; i--) sendBit(op[i]);
    for (int i = 6; i >= 0; i--) sendBit(a[i]);
  endtask

  task automatic sendByte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
  endtask

  task automatic readByte(input logic [6:0] a, input int zeros, output logic [7:0] v);
    selectChip();
    for (int z = 0; z < zeros; z++) sendBit(1'b0);
    sendHeader(2'b10, a);
    waitClk(4);
    for (int i = 7; i >= 0; i--) begin
      v[i] = dataOut;
      if (i > 0) begin
        waitClk(8); serClk = 1'b1; waitClk(8); serClk = 1'b0; waitClk(4);
      end
    end
    deselectChip();
  endtask

  task automatic probeBusy(output logic lvl);
    chipSel = 1'b1; waitClk(6);
    lvl = dataOut;
    chipSel = 1'b0; waitClk(4);
  endtask

  task automatic progCmd(input logic [1:0] op, input logic [6:0] a,
                         input logic hasData, input logic [7:0] d);
    selectChip();
    sendHeader(op, a);
    if (hasData) sendByte(d);
    deselectChip();
  endtask

  task automatic waitIdle();
    waitClk(WR + 60);
  endtask

  task automatic testReset();
    logic [7:0] v;
    chk("R1 dataOut high while deselected", {7'd0, dataOut}, 8'h01);
    readByte(7'h00, 0, v);
    chk("R1 reset byte at 0x00", v, 8'hFF);
    readByte(7'h41, 0, v);
    chk("R1 reset byte at 0x41", v, 8'hFF);
  endtask

  task automatic testWriteBusy();
    logic lvl;
    logic [7:0] v;
    progCmd(2'b00, 7'b1100000, 1'b0, 8'h00);
    progCmd(2'b01, 7'h00, 1'b1, 8'h5A);
    probeBusy(lvl);
    chk("R9 busy low after write", {7'd0, lvl}, 8'h00);
    waitIdle();
    probeBusy(lvl);
    chk("R9 ready high after write time", {7'd0, lvl}, 8'h01);
    readByte(7'h00, 0, v);
    chk("R4 R6 write 0x5A to 0x00", v, 8'h5A);
  endtask

  task automatic testTopAddr();
    logic [7:0] v;
    progCmd(2'b01, 7'h7F, 1'b1, 8'hA5);
    waitIdle();
    readByte(7'h7F, 0, v);
    chk("R4 R3 write top address 0x7F", v, 8'hA5);
    readByte(7'h00, 0, v);
    chk("R4 neighbour 0x00 untouched", v, 8'h5A);
  endtask

  task automatic testErase();
    logic [7:0] v;
    progCmd(2'b11, 7'h00, 1'b0, 8'h00);
    waitIdle();
    readByte(7'h00, 0, v);
    chk("R5 erase 0x00", v, 8'hFF);
    readByte(7'h7F, 0, v);
    chk("R5 erase leaves 0x7F", v, 8'hA5);
  endtask

  task automatic testFillAndWipe();
    logic [7:0] v;
    logic lvl;
    progCmd(2'b00, 7'b0100000, 1'b1, 8'h3C);
    probeBusy(lvl);
    chk("R9 busy after write-all", {7'd0, lvl}, 8'h00);
    waitIdle();
    readByte(7'h10, 0, v);
    chk("R7 write-all at 0x10", v, 8'h3C);
    readByte(7'h7F, 3, v);
    chk("R2 R7 leading zeros then read 0x7F", v, 8'h3C);
    progCmd(2'b00, 7'b1000000, 1'b0, 8'h00);
    waitIdle();
    readByte(7'h22, 0, v);
    chk("R7 erase-all at 0x22", v, 8'hFF);
  endtask

  task automatic testAbort();
    logic [7:0] v;
    logic lvl;
    selectChip();
    sendHeader(2'b01, 7'h06);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    deselectChip();
    probeBusy(lvl);
    chk("R11 no busy after abandoned write", {7'd0, lvl}, 8'h01);
    readByte(7'h06, 0, v);
    chk("R11 abandoned write leaves 0x06", v, 8'hFF);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] v;
    selectChip();
    sendHeader(2'b01, 7'h06);
    sendByte(8'h77);
    deselectChip();
    progCmd(2'b00, 7'b0000000, 1'b0, 8'h00);
    waitIdle();
    progCmd(2'b01, 7'h07, 1'b1, 8'h88);
    waitIdle();
    readByte(7'h07, 0, v);
    chk("R10 lock sent while busy ignored", v, 8'h88);
    readByte(7'h06, 0, v);
    chk("R4 write 0x77 to 0x06", v, 8'h77);
  endtask

  task automatic testLocked();
    logic [7:0] v;
    logic lvl;
    progCmd(2'b00, 7'b0000000, 1'b0, 8'h00);
    progCmd(2'b01, 7'h06, 1'b1, 8'h11);
    probeBusy(lvl);
    chk("R8 locked write starts no busy", {7'd0, lvl}, 8'h01);
    readByte(7'h06, 0, v);
    chk("R8 R6 locked write ignored", v, 8'h77);
    progCmd(2'b00, 7'b1000000, 1'b0, 8'h00);
    readByte(7'h07, 0, v);
    chk("R8 locked erase-all ignored", v, 8'h88);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testWriteBusy();
    testTopAddr();
    testErase();
    testFillAndWipe();
    testAbort();
    testBusyIgnore();
    testLocked();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule